// File: doc/BRIEF.md
# Software Watchdog Timer with One-Shot Protection Register

This block watches over software progress. A prescaled count runs down from a selected period, and software must restart it before it reaches zero by writing a two-byte key sequence to a service register. If the count runs out, the block asks for a system reset or raises a top-priority interrupt. A setting in a protection register picks which one.

The protection register holds three settings: enable, action and a 3-bit period index with eight choices. It takes exactly one write after reset. Every later write is dropped until the next reset, so runaway code cannot turn the watchdog off. After reset the watchdog already runs, uses its longest period and resets the system on expiry. A freeze input, with a companion control input, decides whether counting pauses while the system is halted for debug.

Top module: `sw_watchdog`

## Requirements
- R1: Control register bit 1 selects the action on expiry. When it is 1, `rst_req` is raised. When it is 0, `irq_req` is raised.
- R2: The expiry period is PRESCALE * 2^(BASE_LOG2 + sel) clock cycles after the last reload, where sel is control bits 4:2. With the defaults this is 64 cycles for sel 0, 128 for sel 1 and 8192 for sel 7.
- R3: After reset the control register reads 0x1F: bit 0 is 1 (enabled), bit 1 is 1 (reset action), sel is 7, and the lock flag in bit 7 is 0. Both requests are low, and the first expiry comes 8192 cycles after reset is released.
- R4: When control bit 0 (enable) is 0, no request is ever raised.
- R5: The first write to the control register (address 0) after reset is accepted. It sets the lock flag, read back in bit 7, and reloads the count. Any later write changes neither the settings nor the count.
- R6: While `freeze` is 1 and `frz_run` is 0, counting pauses, and each paused cycle delays expiry by one cycle. When `frz_run` is 1, freeze has no effect.
- R7: `rst_req` is a pulse one cycle wide. `irq_req` stays high until `irq_clr` is sampled high, and it goes low at that edge.
- R8: Writing 0x55 and then 0xAA to the service register (address 1) reloads the full period of the current sel. The reload takes effect at the edge of the 0xAA write.
- R9: Writing any other value after 0x55 cancels the sequence and does not reload the count. A new 0x55 starts the sequence again.
- R10: If a service reload lands in the same cycle as an expiry, the reload wins. No request is raised, and the next expiry comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_cs |
| bus_addr | input | 1 | 0 selects the control register, 1 selects the service register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: {lock, 2'b0, sel, action, enable} at address 0, zero at address 1 |
| freeze | input | 1 | Debug halt indication |
| frz_run | input | 1 | 1 keeps the watchdog counting during freeze |
| irq_clr | input | 1 | Clears the sticky interrupt request |
| rst_req | output | 1 | System reset request pulse |
| irq_req | output | 1 | Highest-priority interrupt request, held until cleared |

## Verification
A service completion and a period expiry can land on the same clock edge. The bench provokes this by timing the 0xAA write so that its edge is exactly the final edge of the period. It then requires that no reset pulse appears and that the next pulse comes one full period after that edge. A related overlap tests the one-shot lock: a second control write, sent partway through a period, must leave both the read-back value and the expiry time unchanged.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef struct packed {
        logic [2:0] sel;
        logic       act_rst;
        logic       en;
    } wdg_cfg_t;

    localparam wdg_cfg_t CFG_RESET = '{sel: 3'd7, act_rst: 1'b1, en: 1'b1};

    localparam logic       ADDR_CTRL = 1'b0;
    localparam logic       ADDR_SVC  = 1'b1;
    localparam logic [7:0] SVC_ARM   = 8'h55;
    localparam logic [7:0] SVC_FIRE  = 8'hAA;

endpackage

// File: rtl/wdg_cfg.sv
module wdg_cfg
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [4:0] wdata_i,
    output wdg_cfg_t   cfg_o,
    output logic       locked_o,
    output logic       accept_o
);
    typedef struct packed {
        wdg_cfg_t cfg;
        logic     locked;
    } cfg_st_t;

    cfg_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        accept_o = wr_i && !st_q.locked;
        if (accept_o) begin
            st_d.cfg    = wdg_cfg_t'(wdata_i);
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cfg: CFG_RESET, locked: 1'b0};
        else        st_q <= st_d;
    end

    assign cfg_o    = st_q.cfg;
    assign locked_o = st_q.locked;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> (st_q.locked && $stable(st_q.cfg))); // R5

endmodule

// File: rtl/wdg_svc.sv
module wdg_svc
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic       done_o
);
    typedef struct packed {
        logic armed;
    } svc_st_t;

    svc_st_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (wr_i) begin
            if (wdata_i == SVC_ARM) begin
                st_d.armed = 1'b1;
            end else if (st_q.armed && wdata_i == SVC_FIRE) begin
                done_o     = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{armed: 1'b0};
        else        st_q <= st_d;
    end

    AST_SVC_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !st_q.armed); // R8

endmodule

// File: rtl/wdg_cnt.sv
module wdg_cnt #(
    parameter int PRESCALE  = 4,
    parameter int BASE_LOG2 = 4,
    parameter logic [2:0] RST_SEL = 3'd7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       reload_i,
    input  logic [2:0] reload_sel_i,
    input  logic [2:0] sel_i,
    output logic       expire_o
);
    localparam int CNT_W = BASE_LOG2 + 8;
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_q, st_d;
    logic    tick;

    function automatic logic [CNT_W-1:0] period_of(input logic [2:0] s);
        period_of = CNT_W'(1) << (BASE_LOG2 + 32'(s));
    endfunction

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        tick     = run_i && (st_q.pre == PRE_LAST);
        if (reload_i) begin
            st_d.pre = '0;
            st_d.cnt = period_of(reload_sel_i);
        end else if (run_i) begin
            st_d.pre = tick ? '0 : st_q.pre + 1'b1;
            if (tick) begin
                if (st_q.cnt == CNT_W'(1)) begin
                    expire_o = 1'b1;
                    st_d.cnt = period_of(sel_i);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pre: '0, cnt: period_of(RST_SEL)};
        else        st_q <= st_d;
    end

    AST_HALT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !reload_i) |=> ($stable(st_q.cnt) && $stable(st_q.pre))); // R6
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != '0); // R2

endmodule

// File: rtl/sw_watchdog.sv
module sw_watchdog
    import wdg_pkg::*;
#(
    parameter int PRESCALE  = 4,
    parameter int BASE_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       freeze,
    input  logic       frz_run,
    input  logic       irq_clr,
    output logic       rst_req,
    output logic       irq_req
);
    typedef struct packed {
        logic rst;
        logic irq;
    } out_st_t;

    out_st_t  st_q, st_d;
    wdg_cfg_t cfg;
    logic     locked, cfg_accept, svc_done, expire, run, reload;
    logic     ctrl_wr, svc_wr;
    logic [2:0] reload_sel;

    assign ctrl_wr = bus_cs && bus_we && (bus_addr == ADDR_CTRL);
    assign svc_wr  = bus_cs && bus_we && (bus_addr == ADDR_SVC);

    wdg_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr), .wdata_i(bus_wdata[4:0]),
        .cfg_o(cfg), .locked_o(locked), .accept_o(cfg_accept)
    );

    wdg_svc u_svc (
        .clk(clk), .rst_n(rst_n), .wr_i(svc_wr), .wdata_i(bus_wdata),
        .done_o(svc_done)
    );

    assign run        = cfg.en && !(freeze && !frz_run);
    assign reload     = cfg_accept || svc_done;
    assign reload_sel = cfg_accept ? bus_wdata[4:2] : cfg.sel;

    wdg_cnt #(.PRESCALE(PRESCALE), .BASE_LOG2(BASE_LOG2), .RST_SEL(CFG_RESET.sel)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .reload_i(reload),
        .reload_sel_i(reload_sel), .sel_i(cfg.sel), .expire_o(expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rst = expire && cfg.act_rst;
        st_d.irq = (expire && !cfg.act_rst) || (st_q.irq && !irq_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req   = st_q.rst;
    assign irq_req   = st_q.irq;
    assign bus_rdata = (bus_addr == ADDR_CTRL) ? {locked, 2'b00, cfg} : 8'h00;

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_clr) |=> irq_req); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en && !irq_req) |=> !(rst_req || irq_req)); // R4

endmodule

// File: tb/tb_sw_watchdog.sv
module tb_sw_watchdog;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_cs, bus_we, bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       freeze, frz_run, irq_clr;
    logic       rst_req, irq_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sw_watchdog dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .freeze(freeze), .frz_run(frz_run), .irq_clr(irq_clr),
        .rst_req(rst_req), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_cs = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        freeze = 0; frz_run = 0; irq_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_cs = 0; bus_we = 0; bus_addr = 0;
    endtask

    task automatic rd_ctrl(input string req, input logic [7:0] exp);
        bus_addr = 0;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    // Expects the chosen request to stay low for n-1 edges and rise at edge n.
    task automatic fire_after(input int n, input bit is_irq, input string req);
        logic seen = 1'b0;
        for (int i = 0; i < n - 1; i++) begin
            edges(1);
            if ((is_irq ? irq_req : rst_req) || (is_irq ? rst_req : irq_req)) seen = 1'b1;
        end
        chk({req, " quiet before expiry"}, {7'd0, seen}, 8'd0);
        edges(1);
        chk({req, " request at expiry"}, {7'd0, is_irq ? irq_req : rst_req}, 8'd1);
    endtask

    task automatic t_reset_default();
        do_reset();
        rd_ctrl("R3 ctrl after reset", 8'h1F);
        chk("R3 outputs low", {6'd0, rst_req, irq_req}, 8'd0);
        fire_after(8192, 1'b0, "R3 R2 default period R1 reset action");
        edges(1);
        chk("R7 reset pulse one cycle", {7'd0, rst_req}, 8'd0);
    endtask

    task automatic t_lock_irq();
        do_reset();
        wr(0, 8'h01);
        rd_ctrl("R5 lock flag set", 8'h81);
        edges(20);
        wr(0, 8'h00);
        rd_ctrl("R5 second write ignored", 8'h81);
        fire_after(64 - 21, 1'b1, "R5 R1 irq expiry unchanged by ignored write");
        edges(20);
        chk("R7 irq held", {7'd0, irq_req}, 8'd1);
        irq_clr = 1;
        edges(1);
        irq_clr = 0;
        chk("R7 irq cleared", {7'd0, irq_req}, 8'd0);
    endtask

    task automatic t_disable();
        logic seen = 1'b0;
        do_reset();
        wr(0, 8'h00);
        rd_ctrl("R4 disabled readback", 8'h80);
        for (int i = 0; i < 300; i++) begin
            edges(1);
            if (rst_req || irq_req) seen = 1'b1;
        end
        chk("R4 no request while disabled", {7'd0, seen}, 8'd0);
    endtask

    task automatic t_service();
        do_reset();
        wr(0, 8'h07);
        edges(100);
        wr(1, 8'h55);
        wr(1, 8'hAA);
        fire_after(128, 1'b0, "R8 service reload sel1");
    endtask

    task automatic t_bad_service();
        do_reset();
        wr(0, 8'h07);
        wr(1, 8'h55);
        wr(1, 8'h12);
        wr(1, 8'hAA);
        fire_after(125, 1'b0, "R9 broken sequence no reload");
        wr(1, 8'h55);
        wr(1, 8'h12);
        wr(1, 8'h55);
        wr(1, 8'hAA);
        fire_after(128, 1'b0, "R9 restarted sequence reloads");
    endtask

    task automatic t_freeze();
        do_reset();
        wr(0, 8'h01);
        edges(10);
        freeze = 1;
        edges(30);
        freeze = 0;
        fire_after(64 + 30 - 40, 1'b1, "R6 freeze halts count");
        do_reset();
        frz_run = 1;
        wr(0, 8'h01);
        edges(10);
        freeze = 1;
        edges(30);
        freeze = 0;
        fire_after(64 - 40, 1'b1, "R6 freeze ignored when frz_run");
    endtask

    task automatic t_collision();
        do_reset();
        wr(0, 8'h07);
        wr(1, 8'h55);
        edges(126);
        wr(1, 8'hAA);
        chk("R10 reload beats expiry", {6'd0, rst_req, irq_req}, 8'd0);
        fire_after(128, 1'b0, "R10 next expiry one period later");
    endtask

    initial begin
        fork
            begin
                t_reset_default();
                t_lock_irq();
                t_disable();
                t_service();
                t_bad_service();
                t_freeze();
                t_collision();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule